// File: doc/BRIEF.md
# Auxiliary Control Register with Dual Data Pointers

This block holds the auxiliary control byte of an 8051-style core together with two 16-bit data pointers. Bit 0 of the control byte selects which pointer is active; every pointer load, pointer increment and pointer read goes to that pointer alone. Bit 3 requests a software reset of the block. Bit 2 is fixed at zero. Because of that fixed zero, a single increment of the control byte flips the select bit. Any carry out of bit 1 dies at bit 2, so the upper bits are never disturbed. Code can therefore swap pointers with a plain increment of the register.

A write that sets bit 3 starts a short reset sequencer with three states.

- **ST_RUN:** normal operation. A write that sets bit 3 moves the sequencer to ST_REQ.
- **ST_REQ:** the request is visible in the register. The sequencer moves to ST_PULSE on the next clock, without condition.
- **ST_PULSE:** the reset output is high for exactly this one clock. At the end of the clock, both pointers and the whole control byte return to zero and the sequencer goes back to ST_RUN.

While the sequencer is in ST_REQ or ST_PULSE, all register and pointer operations are ignored.

Top module: `aux_dptr_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the control byte reads 0x00, the pointer read port reads 0x0000, `sel_out` is 0 and `soft_rst_o` is 0.
- R2: Bit 2 of the control byte always reads 0. Writing 1 to bit 2 has no effect.
- R3: A register write stores bits 7:4, 1 and 0 exactly as written. The value can be read on the next cycle.
- R4: A register increment (with no write in the same cycle) adds one to the byte and then forces bit 2 to zero. The effects are: bit 0 toggles, bit 1 takes the carry from bit 0, and bits 7:3 never change. For example, 0x03 becomes 0x00 and 0xF3 becomes 0xF0.
- R5: A pointer load writes `ptr_ld_data` into the pointer chosen by bit 0 (0 chooses pointer A, 1 chooses pointer B). The other pointer keeps its value.
- R6: A pointer increment adds one to the selected pointer and wraps from 0xFFFF to 0x0000.
- R7: `ptr_rd_data` shows the pointer chosen by bit 0 of the control byte, and `sel_out` equals that bit.
- R8: When a pointer load and a pointer increment occur in the same cycle, the load wins.
- R9: A write with bit 3 set makes bit 3 read 1 on the next cycle (ST_REQ). `soft_rst_o` is then high for exactly the following single cycle (ST_PULSE).
- R10: After the `soft_rst_o` pulse, both pointers are 0x0000 and the control byte is 0x00.
- R11: Register writes, register increments, pointer loads and pointer increments issued in ST_REQ or ST_PULSE have no effect.
- R12: A pointer operation in the same cycle as a register write uses the select bit held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write the control byte |
| reg_wr_data | input | 8 | Data for the control byte write |
| reg_inc | input | 1 | Increment the control byte |
| reg_rd_data | output | 8 | Current control byte |
| ptr_ld_en | input | 1 | Load the selected pointer |
| ptr_ld_data | input | 16 | Value for the pointer load |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_rd_data | output | 16 | Value of the selected pointer |
| sel_out | output | 1 | Current pointer select bit |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
A wrong select bit shows up on the cycle after the faulty update: `ptr_rd_data` jumps to the other pointer's value and `sel_out` flips. The effect of a bad increment, such as a carry leaking past bit 2, is visible one cycle later in bits 7:3 of `reg_rd_data`. A fault in the reset sequencer shows up within two cycles of the request. The pulse may come early, late, or for two cycles, or the pointers may fail to read zero right after it. Pointer faults stay hidden until the pointer is selected, so every check alternates the select bit so that both pointers are read back.

// File: rtl/aux_dptr_pkg.sv
`timescale 1ns/1ps
package aux_dptr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_REQ   = 2'd1,
        ST_PULSE = 2'd2
    } srst_state_e;

endpackage

// File: rtl/srst_seq.sv
`timescale 1ns/1ps
module srst_seq
    import aux_dptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    output logic ops_en,
    output logic clear_all,
    output logic soft_rst
);

    srst_state_e state_q;
    srst_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (req_set) state_d = ST_REQ;
            ST_REQ:   state_d = ST_PULSE;
            ST_PULSE: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        ops_en    = 1'b0;
        clear_all = 1'b0;
        soft_rst  = 1'b0;
        unique case (state_q)
            ST_RUN:   ops_en = 1'b1;
            ST_REQ:   ops_en = 1'b0;
            ST_PULSE: begin
                clear_all = 1'b1;
                soft_rst  = 1'b1;
            end
            default:  ops_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/aux_ctrl_reg.sv
`timescale 1ns/1ps
module aux_ctrl_reg #(
    parameter int REG_W    = 8,
    parameter int ZERO_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ops_en,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             inc,
    output logic [REG_W-1:0] aux_q
);

    localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << ZERO_BIT);

    logic [REG_W-1:0] aux_d;
    logic [REG_W-1:0] aux_plus;

    // The zero held in ZERO_BIT absorbs any carry rippling up from below.
    assign aux_plus = aux_q + REG_W'(1);

    always_comb begin
        aux_d = aux_q;
        if (clear) begin
            aux_d = '0;
        end else if (ops_en && wr_en) begin
            aux_d = wr_data & KEEP_MASK;
        end else if (ops_en && inc) begin
            aux_d = aux_plus & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else begin
            aux_q <= aux_d;
        end
    end

endmodule

// File: rtl/dptr_bank.sv
`timescale 1ns/1ps
module dptr_bank #(
    parameter int PTR_W = 16,
    parameter int N_PTR = 2,
    localparam int SEL_W = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ops_en,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_data,
    input  logic             inc,
    output logic [PTR_W-1:0] rd_data
);

    logic [PTR_W-1:0] ptr_q [N_PTR];

    for (genvar gi = 0; gi < N_PTR; gi++) begin : g_ptr
        logic hit;
        assign hit = ops_en && (sel == SEL_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[gi] <= '0;
            end else if (clear) begin
                ptr_q[gi] <= '0;
            end else if (hit && ld_en) begin
                ptr_q[gi] <= ld_data;
            end else if (hit && inc) begin
                ptr_q[gi] <= ptr_q[gi] + PTR_W'(1);
            end
        end
    end

    assign rd_data = ptr_q[sel];

endmodule

// File: rtl/aux_dptr_unit.sv
`timescale 1ns/1ps
module aux_dptr_unit #(
    parameter int REG_W    = 8,
    parameter int PTR_W    = 16,
    parameter int SEL_BIT  = 0,
    parameter int ZERO_BIT = 2,
    parameter int SRST_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic             reg_inc,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             ptr_ld_en,
    input  logic [PTR_W-1:0] ptr_ld_data,
    input  logic             ptr_inc,
    output logic [PTR_W-1:0] ptr_rd_data,
    output logic             sel_out,
    output logic             soft_rst_o
);

    localparam int N_PTR = 2;

    logic             ops_en;
    logic             clear_all;
    logic             req_set;
    logic [REG_W-1:0] aux_q;

    assign req_set = reg_wr_en && reg_wr_data[SRST_BIT];

    srst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_set   (req_set),
        .ops_en    (ops_en),
        .clear_all (clear_all),
        .soft_rst  (soft_rst_o)
    );

    aux_ctrl_reg #(
        .REG_W    (REG_W),
        .ZERO_BIT (ZERO_BIT)
    ) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops_en  (ops_en),
        .clear   (clear_all),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .inc     (reg_inc),
        .aux_q   (aux_q)
    );

    dptr_bank #(
        .PTR_W (PTR_W),
        .N_PTR (N_PTR)
    ) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops_en  (ops_en),
        .clear   (clear_all),
        .sel     (aux_q[SEL_BIT]),
        .ld_en   (ptr_ld_en),
        .ld_data (ptr_ld_data),
        .inc     (ptr_inc),
        .rd_data (ptr_rd_data)
    );

    assign reg_rd_data = aux_q;
    assign sel_out     = aux_q[SEL_BIT];

endmodule

// File: rtl/aux_dptr_chk.sv
`timescale 1ns/1ps
module aux_dptr_chk #(
    parameter int REG_W    = 8,
    parameter int PTR_W    = 16,
    parameter int SEL_BIT  = 0,
    parameter int ZERO_BIT = 2,
    parameter int SRST_BIT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_inc,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             ptr_ld_en,
    input logic             ptr_inc,
    input logic [PTR_W-1:0] ptr_rd_data,
    input logic             soft_rst_o
);

    AST_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[ZERO_BIT] == 1'b0); // R2

    AST_INC_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_inc && !reg_wr_en && !reg_rd_data[SRST_BIT]) |=>
        (reg_rd_data[REG_W-1:3] == $past(reg_rd_data[REG_W-1:3]) &&
         reg_rd_data[SEL_BIT] != $past(reg_rd_data[SEL_BIT]))); // R4

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_ld_en && !reg_wr_en && !reg_inc &&
         !reg_rd_data[SRST_BIT] && ptr_rd_data == {PTR_W{1'b1}}) |=>
        (ptr_rd_data == '0)); // R6

    AST_REQ_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[SRST_BIT] && !soft_rst_o) |=>
        (soft_rst_o && $stable(reg_rd_data) && $stable(ptr_rd_data))); // R11

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o); // R9

    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (reg_rd_data == '0 && ptr_rd_data == '0)); // R10

endmodule

bind aux_dptr_unit aux_dptr_chk #(
    .REG_W    (REG_W),
    .PTR_W    (PTR_W),
    .SEL_BIT  (SEL_BIT),
    .ZERO_BIT (ZERO_BIT),
    .SRST_BIT (SRST_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_inc     (reg_inc),
    .reg_rd_data (reg_rd_data),
    .ptr_ld_en   (ptr_ld_en),
    .ptr_inc     (ptr_inc),
    .ptr_rd_data (ptr_rd_data),
    .soft_rst_o  (soft_rst_o)
);

// File: tb/aux_dptr_unit_tb_top.sv
`timescale 1ns/1ps
module aux_dptr_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic        reg_inc;
    logic [7:0]  reg_rd_data;
    logic        ptr_ld_en;
    logic [15:0] ptr_ld_data;
    logic        ptr_inc;
    logic [15:0] ptr_rd_data;
    logic        sel_out;
    logic        soft_rst_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    aux_dptr_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_inc     (reg_inc),
        .reg_rd_data (reg_rd_data),
        .ptr_ld_en   (ptr_ld_en),
        .ptr_ld_data (ptr_ld_data),
        .ptr_inc     (ptr_inc),
        .ptr_rd_data (ptr_rd_data),
        .sel_out     (sel_out),
        .soft_rst_o  (soft_rst_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [7:0]  wdata;
        logic        inc;
        logic        ld;
        logic [15:0] ldata;
        logic        pinc;
        logic [7:0]  exp_reg;
        logic [15:0] exp_ptr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hF2, 1'b0, 1'b0, 16'h0000, 1'b0, 8'hF2, 16'h0000, 4'd3},  // R3
        '{1'b1, 8'h04, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 16'h0000, 4'd2},  // R2
        '{1'b0, 8'h00, 1'b0, 1'b1, 16'h1234, 1'b0, 8'h00, 16'h1234, 4'd5},  // R5
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h01, 16'h0000, 4'd7},  // R7
        '{1'b0, 8'h00, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h01, 16'hFFFF, 4'd5},  // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 8'h01, 16'h0000, 4'd6},  // R6
        '{1'b0, 8'h00, 1'b0, 1'b1, 16'hFFFE, 1'b1, 8'h01, 16'hFFFE, 4'd8},  // R8
        '{1'b0, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 8'h01, 16'hFFFF, 4'd6},  // R6
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h02, 16'h1234, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h03, 16'hFFFF, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00, 16'h1234, 4'd4},  // R4
        '{1'b1, 8'hF0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'hF0, 16'h1234, 4'd3},  // R3
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'hF1, 16'hFFFF, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'hF2, 16'h1234, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'hF3, 16'hFFFF, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 8'hF0, 16'h1234, 4'd4},  // R4
        '{1'b1, 8'hF1, 1'b0, 1'b1, 16'hABCD, 1'b0, 8'hF1, 16'hFFFF, 4'd12}, // R12
        '{1'b1, 8'hF0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'hF0, 16'hABCD, 4'd12}  // R12
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic wr, input logic [7:0] wd, input logic inc,
                         input logic ld, input logic [15:0] ldd, input logic pi);
        @(negedge clk);
        reg_wr_en   = wr;
        reg_wr_data = wd;
        reg_inc     = inc;
        ptr_ld_en   = ld;
        ptr_ld_data = ldd;
        ptr_inc     = pi;
        @(posedge clk);
        #1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        reg_wr_en = 1'b0; reg_wr_data = '0; reg_inc = 1'b0;
        ptr_ld_en = 1'b0; ptr_ld_data = '0; ptr_inc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reg", 32'(reg_rd_data), 32'h00);
        chk("R1 ptr", 32'(ptr_rd_data), 32'h0000);
        chk("R1 sel", 32'(sel_out), 32'h0);
        chk("R1 srst", 32'(soft_rst_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].wr, VECS[i].wdata, VECS[i].inc,
                  VECS[i].ld, VECS[i].ldata, VECS[i].pinc);
            chk($sformatf("R%0d reg v%0d", VECS[i].req, i), 32'(reg_rd_data), 32'(VECS[i].exp_reg));
            chk($sformatf("R%0d ptr v%0d", VECS[i].req, i), 32'(ptr_rd_data), 32'(VECS[i].exp_ptr));
            chk($sformatf("R7 sel v%0d", i), 32'(sel_out), 32'(VECS[i].exp_reg[0]));
        end

        // R9: request with select set; pulse not yet high
        apply(1'b1, 8'h09, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R9 req visible", 32'(reg_rd_data), 32'h09);
        chk("R9 no early pulse", 32'(soft_rst_o), 32'h0);
        chk("R9 ptr B", 32'(ptr_rd_data), 32'hFFFF);
        // R11: operations during the request cycle are ignored
        apply(1'b1, 8'h02, 1'b1, 1'b1, 16'h5555, 1'b1);
        chk("R9 pulse high", 32'(soft_rst_o), 32'h1);
        chk("R11 reg held", 32'(reg_rd_data), 32'h09);
        chk("R11 ptr held", 32'(ptr_rd_data), 32'hFFFF);
        // R10: everything cleared after the pulse; the pulse lasts one cycle
        apply(1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R9 pulse gone", 32'(soft_rst_o), 32'h0);
        chk("R10 reg clear", 32'(reg_rd_data), 32'h00);
        chk("R10 ptr A clear", 32'(ptr_rd_data), 32'h0000);
        apply(1'b1, 8'h01, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R10 ptr B clear", 32'(ptr_rd_data), 32'h0000);

        // R1: hardware reset mid-run
        apply(1'b0, 8'h00, 1'b0, 1'b1, 16'h7777, 1'b0);
        chk("R5 ptr B load", 32'(ptr_rd_data), 32'h7777);
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr_en = 1'b0; ptr_ld_en = 1'b0;
        #1;
        chk("R1 async reg", 32'(reg_rd_data), 32'h00);
        chk("R1 async ptr", 32'(ptr_rd_data), 32'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 8'h01, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R1 ptr B after reset", 32'(ptr_rd_data), 32'h0000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule